// File: doc/BRIEF.md
# Branch-Count Speculation Throttle

This block slows the rename stage when too much unresolved speculation is in flight. It keeps one running count of branches that have been renamed but not yet resolved. Each branch counts the same, because there is no confidence estimator. Each cycle it compares that registered count with a ceiling that the current performance state selects. When the count is at or above the ceiling, it raises a rename stall.

The same state code also selects how mispredictions recover. In the top state, checkpoints are kept and recovery happens as soon as a misprediction is detected. In every lower state, checkpoint hardware is switched off and recovery waits for commit. In that mode, a detected misprediction holds rename stalled until the recovery action is reported done. A full pipeline flush empties the count and drops any stall.

The surrounding pipeline reports, every cycle, how many branches were renamed, how many resolved, and how many were removed by a squash. It reads back the stall and the two mode outputs. All outputs are registered.

Top module: `spec_throttle`

## Requirements
- R1: During and right after a synchronous reset, `rename_stall` is 0, `ckpt_en` is 1 and `commit_recov` is 0, which are the top-state values.
- R2: State code 0 is the top state and has no ceiling. Codes 1, 2, 3, 4 and 5 have ceilings of 8, 4, 3, 2 and 1. Codes 6 and 7 use the deepest ceiling, 1.
- R3: Each cycle the count adds `ren_cnt` and subtracts `res_cnt` and `squash_cnt`. A result below zero becomes 0, and a result above 2^CNT_W-1 becomes 2^CNT_W-1.
- R4: `rename_stall` is 1 in the cycle after the registered count is at or above the registered ceiling. It is 0 in the cycle after the count falls below the ceiling, provided no other stall cause is active.
- R5: A new state code sampled at a clock edge sets the ceiling used from the next edge on. While the state in use is the top state, `rename_stall` is 0.
- R6: One cycle after the state code is sampled, `ckpt_en`=1 and `commit_recov`=0 if the code is 0, and `ckpt_en`=0 and `commit_recov`=1 for any other code.
- R7: While `commit_recov` is 1, a `mispred_det` pulse makes `rename_stall` 1 from the next cycle on, until the cycle after `recov_done`. While `commit_recov` is 0, `mispred_det` is ignored.
- R8: `flush_all` clears the count and any misprediction hold, and makes `rename_stall` 0 in the next cycle. It wins over renames in the same cycle.
- R9: A `ren_cnt` or `res_cnt` value above the pipeline width WIDTH (default 4) is treated as WIDTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_cnt | input | CW (3) | Branches renamed this cycle |
| res_cnt | input | CW (3) | Branches resolved this cycle |
| squash_cnt | input | CNT_W (6) | Unresolved branches removed by a squash this cycle |
| flush_all | input | 1 | Full pipeline flush |
| mispred_det | input | 1 | Misprediction detected this cycle |
| recov_done | input | 1 | Commit-time recovery action completed |
| pstate | input | PS_W (3) | Performance state code |
| rename_stall | output | 1 | Stall the rename stage |
| ckpt_en | output | 1 | Checkpoint hardware enabled |
| commit_recov | output | 1 | Recover mispredictions at commit |

## Verification
The bench targets the exact edge at which each ceiling starts to bite. A comparison using greater-than instead of greater-or-equal, or one that reads the unregistered count, would move the stall by one cycle. The bench drives resolves and squashes that exceed the count, so an unsigned underflow would leave the stall stuck high. It also pushes the count past its maximum, so a wrapping counter would drop the stall early. It further checks oversized renames, reserved state codes, a flush that coincides with renames, a misprediction in the top state that must not stall, and a misprediction in a lower state that must hold the stall until recovery completes.

// File: rtl/sthr_pkg.sv
package sthr_pkg;

  // Ceiling on unresolved branches for each performance state code.
  // Code 0 is the top state; its entry is unused because it has no ceiling.
  function automatic int unsigned level_limit(input int unsigned code);
    case (code)
      0:       return 0;
      1:       return 8;
      2:       return 4;
      3:       return 3;
      4:       return 2;
      default: return 1;
    endcase
  endfunction

  typedef enum logic {
    REC_DETECT = 1'b0,
    REC_COMMIT = 1'b1
  } rec_mode_e;

endpackage

// File: rtl/sthr_count.sv
module sthr_count #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 6,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [CW-1:0]    ren_cnt,
  input  logic [CW-1:0]    res_cnt,
  input  logic [CNT_W-1:0] squash_cnt,
  output logic [CNT_W-1:0] cnt_q
);
  localparam int EXT_W = CNT_W + 2;
  localparam logic [EXT_W-1:0] CNT_MAX = EXT_W'((1 << CNT_W) - 1);
  localparam logic [CW-1:0]    W_LIM   = CW'(WIDTH);

  logic [CW-1:0]    ren_c, res_c;
  logic [EXT_W-1:0] add_v, sub_v, diff_v;
  logic [CNT_W-1:0] cnt_nxt;

  // Clamp the per-cycle counts to the pipeline width.
  always_comb begin
    ren_c = (ren_cnt > W_LIM) ? W_LIM : ren_cnt;
    res_c = (res_cnt > W_LIM) ? W_LIM : res_cnt;
  end

  always_comb begin
    add_v  = EXT_W'(cnt_q) + EXT_W'(ren_c);
    sub_v  = EXT_W'(res_c) + EXT_W'(squash_cnt);
    diff_v = add_v - sub_v;
    if (sub_v >= add_v)
      cnt_nxt = '0;
    else if (diff_v > CNT_MAX)
      cnt_nxt = CNT_MAX[CNT_W-1:0];
    else
      cnt_nxt = diff_v[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || flush)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sthr_limit.sv
module sthr_limit #(
  parameter int PS_W  = 3,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PS_W-1:0]  pstate,
  output logic [CNT_W-1:0] lim_q,
  output logic             top_q
);
  localparam int NCODE = 1 << PS_W;

  logic [CNT_W-1:0] lim_tab [NCODE];

  for (genvar g = 0; g < NCODE; g++) begin : g_tab
    assign lim_tab[g] = CNT_W'(sthr_pkg::level_limit(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= 1'b1;
      lim_q <= lim_tab[0];
    end else begin
      top_q <= (pstate == '0);
      lim_q <= lim_tab[pstate];
    end
  end
endmodule

// File: rtl/sthr_recov.sv
module sthr_recov #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] pstate,
  input  logic            flush,
  input  logic            mispred_det,
  input  logic            recov_done,
  output logic            ckpt_en,
  output logic            commit_recov,
  output logic            hold_nxt
);
  sthr_pkg::rec_mode_e mode_q;
  logic                hold_q;

  // A misprediction hold exists only under commit-time recovery.
  always_comb begin
    if (flush || recov_done || mode_q == sthr_pkg::REC_DETECT)
      hold_nxt = 1'b0;
    else if (mispred_det)
      hold_nxt = 1'b1;
    else
      hold_nxt = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= sthr_pkg::REC_DETECT;
      ckpt_en <= 1'b1;
      hold_q  <= 1'b0;
    end else begin
      mode_q  <= (pstate == '0) ? sthr_pkg::REC_DETECT : sthr_pkg::REC_COMMIT;
      ckpt_en <= (pstate == '0);
      hold_q  <= hold_nxt;
    end
  end

  assign commit_recov = (mode_q == sthr_pkg::REC_COMMIT);
endmodule

// File: rtl/spec_throttle.sv
module spec_throttle #(
  parameter int WIDTH = 4,
  parameter int CNT_W = 6,
  parameter int PS_W  = 3,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    ren_cnt,
  input  logic [CW-1:0]    res_cnt,
  input  logic [CNT_W-1:0] squash_cnt,
  input  logic             flush_all,
  input  logic             mispred_det,
  input  logic             recov_done,
  input  logic [PS_W-1:0]  pstate,
  output logic             rename_stall,
  output logic             ckpt_en,
  output logic             commit_recov
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             top_q;
  logic             hold_nxt;
  logic             stall_q;

  sthr_count #(.WIDTH(WIDTH), .CNT_W(CNT_W)) count_i (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush_all),
    .ren_cnt    (ren_cnt),
    .res_cnt    (res_cnt),
    .squash_cnt (squash_cnt),
    .cnt_q      (cnt_q)
  );

  sthr_limit #(.PS_W(PS_W), .CNT_W(CNT_W)) limit_i (
    .clk    (clk),
    .rst    (rst),
    .pstate (pstate),
    .lim_q  (lim_q),
    .top_q  (top_q)
  );

  sthr_recov #(.PS_W(PS_W)) recov_i (
    .clk          (clk),
    .rst          (rst),
    .pstate       (pstate),
    .flush        (flush_all),
    .mispred_det  (mispred_det),
    .recov_done   (recov_done),
    .ckpt_en      (ckpt_en),
    .commit_recov (commit_recov),
    .hold_nxt     (hold_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || flush_all)
      stall_q <= 1'b0;
    else
      stall_q <= !top_q && ((cnt_q >= lim_q) || hold_nxt);
  end

  assign rename_stall = stall_q;
endmodule

// File: rtl/sthr_checker.sv
module sthr_checker #(
  parameter int PS_W  = 3,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             flush_all,
  input logic             mispred_det,
  input logic             recov_done,
  input logic [PS_W-1:0]  pstate,
  input logic             rename_stall,
  input logic             ckpt_en,
  input logic             commit_recov,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] lim_q,
  input logic             top_q
);
  AST_TOP_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    ckpt_en && $past(ckpt_en) |-> !rename_stall); // R5

  AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ckpt_en == ($past(pstate) == '0)) && (commit_recov == ($past(pstate) != '0))); // R6

  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !rename_stall); // R8

  AST_MISPRED_HOLD: assert property (@(posedge clk) disable iff (rst)
    commit_recov && mispred_det && !recov_done && !flush_all |=> rename_stall); // R7

  AST_LIMIT_STALL: assert property (@(posedge clk) disable iff (rst)
    !top_q && (cnt_q >= lim_q) && !flush_all |=> rename_stall); // R4
endmodule

bind spec_throttle sthr_checker #(.PS_W(PS_W), .CNT_W(CNT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .flush_all    (flush_all),
  .mispred_det  (mispred_det),
  .recov_done   (recov_done),
  .pstate       (pstate),
  .rename_stall (rename_stall),
  .ckpt_en      (ckpt_en),
  .commit_recov (commit_recov),
  .cnt_q        (cnt_q),
  .lim_q        (lim_q),
  .top_q        (top_q)
);

// File: tb/spec_throttle_tb_top.sv
`timescale 1ns/1ps
module spec_throttle_tb_top;
  localparam int WIDTH = 4;
  localparam int CNT_W = 6;
  localparam int PS_W  = 3;
  localparam int CW    = $clog2(WIDTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0]    ren_cnt = '0, res_cnt = '0;
  logic [CNT_W-1:0] squash_cnt = '0;
  logic flush_all = 1'b0, mispred_det = 1'b0, recov_done = 1'b0;
  logic [PS_W-1:0]  pstate = '0;
  logic rename_stall, ckpt_en, commit_recov;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spec_throttle #(.WIDTH(WIDTH), .CNT_W(CNT_W), .PS_W(PS_W)) dut_i (
    .clk(clk), .rst(rst), .ren_cnt(ren_cnt), .res_cnt(res_cnt),
    .squash_cnt(squash_cnt), .flush_all(flush_all), .mispred_det(mispred_det),
    .recov_done(recov_done), .pstate(pstate), .rename_stall(rename_stall),
    .ckpt_en(ckpt_en), .commit_recov(commit_recov)
  );

  typedef struct packed {
    logic [2:0] ps;
    logic [2:0] ren;
    logic [2:0] res;
    logic       fl;
    logic [5:0] sq;
    logic       mis;
    logic       done;
    logic       e_stall;
    logic       e_ckpt;
    logic       e_commit;
  } vec_t;

  localparam int NV = 30;
  // Expected outputs are those seen just after the edge that samples the row.
  localparam vec_t VEC [NV] = '{
    '{3'd2, 3'd4, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 leave top
    '{3'd2, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 4>=4
    '{3'd2, 3'd0, 3'd1, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R4 still from 4
    '{3'd2, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 3<4 release
    '{3'd3, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R5 old ceiling
    '{3'd3, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 ceiling 3
    '{3'd0, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 lag one edge
    '{3'd0, 3'd4, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 top no stall
    '{3'd0, 3'd0, 3'd0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 ignored in top
    '{3'd1, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 to state 1
    '{3'd1, 3'd1, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 7<8
    '{3'd1, 3'd1, 3'd2, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 8>=8
    '{3'd1, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 net -1
    '{3'd1, 3'd0, 3'd0, 1'b0, 6'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 squash 5
    '{3'd1, 3'd0, 3'd0, 1'b0, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 floor zero
    '{3'd5, 3'd1, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 from 0
    '{3'd5, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 ceiling 1
    '{3'd5, 3'd0, 3'd3, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R3 over-resolve
    '{3'd5, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 floored
    '{3'd5, 3'd0, 3'd0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 hold set
    '{3'd5, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 hold kept
    '{3'd5, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 released
    '{3'd4, 3'd2, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 state 4
    '{3'd4, 3'd0, 3'd0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 with count
    '{3'd4, 3'd0, 3'd0, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 flush
    '{3'd4, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 count cleared
    '{3'd7, 3'd1, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 code 7
    '{3'd7, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R2 code 7 ceil 1
    '{3'd6, 3'd3, 3'd0, 1'b1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R8 flush wins
    '{3'd6, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R8 renames dropped
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] ps, input logic [2:0] ren, input logic [2:0] res,
                      input logic fl, input logic [5:0] sq, input logic mis, input logic done);
    @(negedge clk);
    pstate = ps; ren_cnt = ren; res_cnt = res; flush_all = fl;
    squash_cnt = sq; mispred_det = mis; recov_done = done;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "stall", rename_stall, 1'b0);
    chk("R1", "ckpt", ckpt_en, 1'b1);
    chk("R1", "commit", commit_recov, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ps, VEC[i].ren, VEC[i].res, VEC[i].fl, VEC[i].sq, VEC[i].mis, VEC[i].done);
      chk($sformatf("vec%0d", i), "stall", rename_stall, VEC[i].e_stall);
      chk($sformatf("vec%0d", i), "ckpt", ckpt_en, VEC[i].e_ckpt);
      chk($sformatf("vec%0d", i), "commit", commit_recov, VEC[i].e_commit);
    end

    // R9: oversized rename counts clamp to 4, so two of them give 8.
    step(3'd1, 3'd7, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    step(3'd1, 3'd7, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    step(3'd1, 3'd0, 3'd1, 1'b0, 6'd0, 1'b0, 1'b0);
    chk("R4", "stall at 8", rename_stall, 1'b1);
    step(3'd1, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    chk("R9", "clamped count 7", rename_stall, 1'b0);

    // R3: upper saturation at 63.
    step(3'd0, 3'd0, 3'd0, 1'b1, 6'd0, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) step(3'd0, 3'd4, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    step(3'd1, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    for (int k = 0; k < 14; k++) step(3'd1, 3'd0, 3'd4, 1'b0, 6'd0, 1'b0, 1'b0);
    chk("R3", "stall from 11", rename_stall, 1'b1);
    step(3'd1, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    chk("R3", "stall from 7", rename_stall, 1'b0);

    // R1: reset in the middle of a stall.
    step(3'd5, 3'd1, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    step(3'd5, 3'd0, 3'd0, 1'b0, 6'd0, 1'b0, 1'b0);
    chk("R2", "pre-reset stall", rename_stall, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "stall", rename_stall, 1'b0);
    chk("R1", "ckpt", ckpt_en, 1'b1);
    chk("R1", "commit", commit_recov, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    finished = 1'b1;
    finish_run();
  end
endmodule